// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of a four-bank DDR SDRAM interface on every rising clock edge. It turns each sampled pin pattern into a one-cycle command strobe and keeps a shadow of the device state: which banks hold an open row, the row address each open bank holds, the last mode-register value, and whether a data burst is in flight. A few timing counters run beside that shadow.

The monitor never drives the memory. It sits beside a controller or a bus model and raises sticky flags when the command stream breaks a rule. The rules it checks are: an access to a closed bank, a mode-register load while the device is busy, any command inside the wait windows after a mode-register load or a precharge, and refresh commands spaced too far apart. A synchronous clear input resets the flags. For this device, bit A8 (not A10) selects the all-bank precharge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_strobe` is registered and shows the command sampled at the previous rising edge. Bit 0 is NOP (RAS/CAS/WE = 1/1/1), bit 1 is mode load (0/0/0), bit 2 is ACTIVE (0/1/1), bit 3 is READ (1/0/1), bit 4 is WRITE (1/0/0), bit 5 is PRECHARGE (0/1/0), bit 6 is burst stop (1/1/0) and bit 7 is REFRESH (0/0/1). When chip select is high, every bit is 0 and the other pins have no effect.
- R2: ACTIVE marks the bank named by `ba` as open in `bank_open[ba]`. It stores `addr` as that bank's row in `open_rows[ba*11 +: 11]`.
- R3: When `addr[8]` is low, PRECHARGE closes only the bank named by `ba`. When `addr[8]` is high, it closes every bank and `ba` is ignored. A PRECHARGE to a bank that is already closed changes nothing and raises no flag.
- R4: A READ or WRITE to a closed bank sets `err_idle_access` and starts no burst.
- R5: A mode load copies `addr` into `mode_reg`. If any bank is open or a burst is active when it arrives, it sets `err_mrs_busy`.
- R6: Any command other than NOP or deselect, sampled at one of the TMRD-1 edges after a mode load, sets `err_mrd_window`.
- R7: An ACTIVE to a bank, sampled at one of the TRP-1 edges after a PRECHARGE closed that bank, sets `err_rp_window`.
- R8: A READ or WRITE to an open bank holds `burst_active` high for BURST_LEN/2 cycles. NOP commands do not shorten the burst.
- R9: A burst stop clears `burst_active` at once during a read burst. During a write burst it has no effect.
- R10: If REF_NS*CLK_MHZ/1000 consecutive edges pass without a REFRESH, `err_refresh_late` is set. A REFRESH restarts the count.
- R11: Every error flag stays set until an edge where `err_clr` is high. That edge clears the flags that are not being set again at the same edge.
- R12: While `rst_n` is low at an edge, all strobes, banks, rows, `mode_reg`, the burst flag and the error flags go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of the error flags |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 11 | Address bus A0-A10 |
| cmd_strobe | output | 8 | One-hot decoded command |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 44 | Row held by each bank, 11 bits per bank |
| mode_reg | output | 11 | Last mode-load value |
| burst_active | output | 1 | Data burst in progress |
| err_idle_access | output | 1 | Read/write to closed bank |
| err_mrs_busy | output | 1 | Mode load while busy |
| err_mrd_window | output | 1 | Command inside mode-load wait |
| err_rp_window | output | 1 | Activate inside precharge wait |
| err_refresh_late | output | 1 | Refresh interval exceeded |

## Verification
The bench builds the monitor with TMRD=3, TRP=3, BURST_LEN=4 and CLK_MHZ=5. With these values the refresh limit is 78 edges, so both sides of the refresh threshold can be reached in a short run. Both wait windows are two edges wide, so a command can be placed on the last illegal edge and again on the first legal edge. Each burst is two cycles long, so a burst stop can arrive while a read burst or a write burst is still running.

// File: rtl/sdram_mon_pkg.sv
// Shared command indices for the SDRAM command monitor.
// Assumes the one-hot strobe bit order below is fixed by the port contract.
package sdram_mon_pkg;
    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_MRS = 3'd1,
        C_ACT = 3'd2,
        C_RD  = 3'd3,
        C_WR  = 3'd4,
        C_PRE = 3'd5,
        C_BST = 3'd6,
        C_REF = 3'd7
    } cmd_idx_e;
    localparam int CMD_N = 8;
endpackage

// File: rtl/sdr_cmd_decode.sv
// Combinational command decoder: maps chip select and the three strobe
// pins to a one-hot command vector. Assumes pins are stable at the edge.
module sdr_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    output logic [CMD_N-1:0] cmd_hot
);
    // Decode the strobe triple; deselect yields no command.
    always_comb begin
        cmd_hot = '0;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_hot[C_NOP] = 1'b1;
                3'b000:  cmd_hot[C_MRS] = 1'b1;
                3'b011:  cmd_hot[C_ACT] = 1'b1;
                3'b101:  cmd_hot[C_RD]  = 1'b1;
                3'b100:  cmd_hot[C_WR]  = 1'b1;
                3'b010:  cmd_hot[C_PRE] = 1'b1;
                3'b110:  cmd_hot[C_BST] = 1'b1;
                default: cmd_hot[C_REF] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sdr_bank_track.sv
// Per-bank state tracker: open flag, row register and precharge wait
// counter for each bank. Assumes one command per edge; ACTIVE to an open
// bank simply re-records the row.
module sdr_bank_track #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 8,
    parameter int TRP       = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        act,
    input  logic                        pre,
    input  logic                        rdwr,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] rows,
    output logic                        idle_hit,
    output logic                        rp_hit
);
    localparam int BAW = $clog2(NUM_BANKS);
    localparam int RPW = $clog2(TRP + 1);
    localparam logic [RPW-1:0] RP_LOAD = RPW'(TRP - 1);

    logic              pre_all;
    logic [NUM_BANKS-1:0] rp_busy;

    assign pre_all = addr[AP_BIT];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              open_q;
        logic [ADDR_W-1:0] row_q;
        logic [RPW-1:0]    rp_cnt;
        logic              sel, closing;

        assign sel     = (ba == BAW'(b));
        assign closing = pre && (pre_all || sel) && open_q;

        // Track open state and row for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (act && sel) begin
                open_q <= 1'b1;
                row_q  <= addr;
            end else if (closing) begin
                open_q <= 1'b0;
            end
        end

        // Count down the precharge recovery window after a real close.
        always_ff @(posedge clk) begin
            if (!rst_n)            rp_cnt <= '0;
            else if (closing)      rp_cnt <= RP_LOAD;
            else if (rp_cnt != '0) rp_cnt <= rp_cnt - 1'b1;
        end

        assign bank_open[b]              = open_q;
        assign rows[b*ADDR_W +: ADDR_W]  = row_q;
        assign rp_busy[b]                = (rp_cnt != '0);
    end

    assign idle_hit = rdwr && !bank_open[ba];
    assign rp_hit   = act && rp_busy[ba];

    // R3
    pre_all_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pre && pre_all) |-> (bank_open == '0));
endmodule

// File: rtl/sdr_timing_guard.sv
// Device-wide timing guard: mode-load wait, burst length tracking and
// refresh interval watchdog. Assumes cmd_hot is one-hot or zero and that
// rd_ok says the addressed bank is open.
module sdr_timing_guard
    import sdram_mon_pkg::*;
#(
    parameter int TMRD      = 2,
    parameter int BURST_CYC = 4,
    parameter int REF_LIMIT = 3120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_N-1:0] cmd_hot,
    input  logic             rd_ok,
    input  logic             any_open,
    output logic             burst_active,
    output logic             mrd_hit,
    output logic             mrs_busy_hit,
    output logic             ref_hit
);
    localparam int MW  = $clog2(TMRD + 1);
    localparam int BW  = $clog2(BURST_CYC + 1);
    localparam int RFW = $clog2(REF_LIMIT + 1);
    localparam logic [MW-1:0]  MRD_LOAD = MW'(TMRD - 1);
    localparam logic [BW-1:0]  BST_LOAD = BW'(BURST_CYC);
    localparam logic [RFW-1:0] REF_LAST = RFW'(REF_LIMIT - 1);

    logic [MW-1:0]  mrd_cnt;
    logic [BW-1:0]  bst_cnt;
    logic           bst_is_rd;
    logic [RFW-1:0] ref_cnt;
    logic           exec, start;

    assign exec         = (|cmd_hot) && !cmd_hot[C_NOP];
    assign start        = (cmd_hot[C_RD] || cmd_hot[C_WR]) && rd_ok;
    assign mrd_hit      = exec && (mrd_cnt != '0);
    assign mrs_busy_hit = cmd_hot[C_MRS] && (any_open || burst_active);
    assign ref_hit      = !cmd_hot[C_REF] && (ref_cnt == REF_LAST);
    assign burst_active = (bst_cnt != '0);

    // Count down the wait after a mode load.
    always_ff @(posedge clk) begin
        if (!rst_n)               mrd_cnt <= '0;
        else if (cmd_hot[C_MRS])  mrd_cnt <= MRD_LOAD;
        else if (mrd_cnt != '0)   mrd_cnt <= mrd_cnt - 1'b1;
    end

    // Burst length counter with read-only early stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_cnt   <= '0;
            bst_is_rd <= 1'b0;
        end else if (start) begin
            bst_cnt   <= BST_LOAD;
            bst_is_rd <= cmd_hot[C_RD];
        end else if (cmd_hot[C_BST] && bst_is_rd) begin
            bst_cnt   <= '0;
        end else if (bst_cnt != '0) begin
            bst_cnt   <= bst_cnt - 1'b1;
        end
    end

    // Edges since the last refresh, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ref_cnt <= '0;
        else if (cmd_hot[C_REF])    ref_cnt <= '0;
        else if (ref_cnt != REF_LAST) ref_cnt <= ref_cnt + 1'b1;
    end

    // R8
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |-> $past(cmd_hot[C_RD] || cmd_hot[C_WR]));
    // R9
    write_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !bst_is_rd && cmd_hot[C_BST] && bst_cnt > BW'(1)) |=> burst_active);
endmodule

// File: rtl/sdram_cmd_monitor.sv
// Top of the SDRAM command legality monitor. Registers the decoded command
// strobe, the mode value and the sticky error flags; bank and timing state
// live in the submodules. Assumes a single rank and one command per edge.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 8,
    parameter int TMRD      = 2,
    parameter int TRP       = 3,
    parameter int BURST_LEN = 8,
    parameter int CLK_MHZ   = 200,
    parameter int REF_NS    = 15600
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          err_clr,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [$clog2(NUM_BANKS)-1:0]  ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [CMD_N-1:0]              cmd_strobe,
    output logic [NUM_BANKS-1:0]          bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0]   open_rows,
    output logic [ADDR_W-1:0]             mode_reg,
    output logic                          burst_active,
    output logic                          err_idle_access,
    output logic                          err_mrs_busy,
    output logic                          err_mrd_window,
    output logic                          err_rp_window,
    output logic                          err_refresh_late
);
    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int REF_LIMIT = REF_NS * CLK_MHZ / 1000;
    localparam int NERR      = 5;

    logic [CMD_N-1:0] cmd_hot;
    logic idle_hit, rp_hit, mrd_hit, mrs_hit, ref_hit;
    logic [NERR-1:0] err_q, err_new;

    sdr_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_hot(cmd_hot)
    );

    sdr_bank_track #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .TRP(TRP)
    ) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act(cmd_hot[C_ACT]), .pre(cmd_hot[C_PRE]),
        .rdwr(cmd_hot[C_RD] || cmd_hot[C_WR]),
        .ba(ba), .addr(addr),
        .bank_open(bank_open), .rows(open_rows),
        .idle_hit(idle_hit), .rp_hit(rp_hit)
    );

    sdr_timing_guard #(
        .TMRD(TMRD), .BURST_CYC(BURST_CYC), .REF_LIMIT(REF_LIMIT)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .cmd_hot(cmd_hot),
        .rd_ok(bank_open[ba]), .any_open(|bank_open),
        .burst_active(burst_active), .mrd_hit(mrd_hit),
        .mrs_busy_hit(mrs_hit), .ref_hit(ref_hit)
    );

    assign err_new = {ref_hit, rp_hit, mrd_hit, mrs_hit, idle_hit};

    // Register the decoded command strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_strobe <= '0;
        else        cmd_strobe <= cmd_hot;
    end

    // Latch the address bus on every mode load.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_reg <= '0;
        else if (cmd_hot[C_MRS]) mode_reg <= addr;
    end

    // Sticky error flags: clear on request, new violations win.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & {NERR{!err_clr}}) | err_new;
    end

    assign {err_refresh_late, err_rp_window, err_mrd_window, err_mrs_busy, err_idle_access} = err_q;

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe));
    // R1
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_strobe) |-> !$past(cs_n));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_clr = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [7:0]  cmd_strobe;
    logic [3:0]  bank_open;
    logic [43:0] open_rows;
    logic [10:0] mode_reg;
    logic        burst_active;
    logic        e_idle, e_mrs, e_mrd, e_rp, e_ref;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor #(
        .TMRD(3), .TRP(3), .BURST_LEN(4), .CLK_MHZ(5)
    ) uut (
        .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr),
        .cmd_strobe(cmd_strobe), .bank_open(bank_open), .open_rows(open_rows),
        .mode_reg(mode_reg), .burst_active(burst_active),
        .err_idle_access(e_idle), .err_mrs_busy(e_mrs), .err_mrd_window(e_mrd),
        .err_rp_window(e_rp), .err_refresh_late(e_ref)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one command for one edge; returns after the edge, pins back at NOP.
    task automatic issue(input logic c, input logic r, input logic k, input logic w,
                         input logic [1:0] b, input logic [10:0] a);
        cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = b; addr = a;
        @(negedge clk);
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(0, 1, 1, 1, 0, 0);
    endtask
    task automatic c_mrs(input logic [10:0] v);           issue(0, 0, 0, 0, 0, v); endtask
    task automatic c_act(input logic [1:0] b, input logic [10:0] r); issue(0, 0, 1, 1, b, r); endtask
    task automatic c_rd(input logic [1:0] b);              issue(0, 1, 0, 1, b, 0); endtask
    task automatic c_wr(input logic [1:0] b);              issue(0, 1, 0, 0, b, 0); endtask
    task automatic c_pre(input logic [1:0] b, input logic all); issue(0, 0, 1, 0, b, {2'b0, all, 8'h0}); endtask
    task automatic c_bst();                                issue(0, 1, 1, 0, 0, 0); endtask
    task automatic c_ref();                                issue(0, 0, 0, 1, 0, 0); endtask

    task automatic clr();
        err_clr = 1'b1;
        nop(1);
        err_clr = 1'b0;
    endtask

    // Close everything and let every wait window expire.
    task automatic settle();
        c_pre(0, 1);
        nop(3);
        c_ref();
        clr();
    endtask

    task automatic t_reset();
        chk("R12 strobe", cmd_strobe, 0);
        chk("R12 banks", bank_open, 0);
        chk("R12 rows", open_rows, 0);
        chk("R12 mode", mode_reg, 0);
        chk("R12 burst", burst_active, 0);
        chk("R12 errors", {e_idle, e_mrs, e_mrd, e_rp, e_ref}, 0);
    endtask

    task automatic t_decode();
        nop(1);                      chk("R1 nop", cmd_strobe, 8'h01);
        issue(1, 0, 0, 0, 2, 11'h7FF); chk("R1 deselect", cmd_strobe, 8'h00);
        chk("R1 deselect ignored", mode_reg, 0);
        c_ref();                     chk("R1 refresh", cmd_strobe, 8'h80);
        c_mrs(11'h033);              chk("R1 mode load", cmd_strobe, 8'h02);
        nop(2);
        c_act(0, 11'h010);           chk("R1 active", cmd_strobe, 8'h04);
        c_rd(0);                     chk("R1 read", cmd_strobe, 8'h08);
        c_wr(0);                     chk("R1 write", cmd_strobe, 8'h10);
        c_bst();                     chk("R1 burst stop", cmd_strobe, 8'h40);
        c_pre(0, 0);                 chk("R1 precharge", cmd_strobe, 8'h20);
        settle();
    endtask

    task automatic t_banks();
        c_act(0, 11'h005);
        c_act(2, 11'h4A7);
        chk("R2 open", bank_open, 4'b0101);
        chk("R2 row b0", open_rows[0 +: 11], 11'h005);
        chk("R2 row b2", open_rows[22 +: 11], 11'h4A7);
        c_pre(2, 0);                 chk("R3 single close", bank_open, 4'b0001);
        c_pre(3, 0);                 chk("R3 idle precharge", bank_open, 4'b0001);
        chk("R3 idle precharge no error", {e_idle, e_mrs, e_mrd, e_rp, e_ref}, 0);
        c_act(1, 11'h001);
        c_pre(2, 1);                 chk("R3 all close", bank_open, 4'b0000);
        settle();
    endtask

    task automatic t_idle_access();
        c_rd(1);
        chk("R4 read idle flag", e_idle, 1);
        chk("R4 read idle no burst", burst_active, 0);
        clr();
        chk("R4 cleared", e_idle, 0);
        c_wr(3);
        chk("R4 write idle flag", e_idle, 1);
        settle();
    endtask

    task automatic t_mode();
        c_mrs(11'h2A5);
        chk("R5 latch", mode_reg, 11'h2A5);
        chk("R5 legal load", e_mrs, 0);
        nop(2);
        c_act(1, 11'h00F);
        chk("R6 legal after wait", e_mrd, 0);
        nop(1);
        c_mrs(11'h15A);
        chk("R5 load while open", e_mrs, 1);
        chk("R5 latch anyway", mode_reg, 11'h15A);
        settle();
        c_mrs(11'h001);
        nop(1);
        c_ref();
        chk("R6 last illegal edge", e_mrd, 1);
        settle();
        c_act(0, 11'h0);
        c_rd(0);
        c_mrs(11'h002);
        chk("R5 load during burst", e_mrs, 1);
        settle();
    endtask

    task automatic t_precharge_wait();
        c_act(1, 11'h0AA);
        c_pre(1, 0);
        nop(1);
        c_act(1, 11'h0AB);
        chk("R7 last illegal edge", e_rp, 1);
        chk("R2 row still recorded", open_rows[11 +: 11], 11'h0AB);
        clr();
        c_pre(1, 0);
        nop(2);
        c_act(1, 11'h0AC);
        chk("R7 first legal edge", e_rp, 0);
        c_pre(2, 0);
        c_act(2, 11'h0);
        chk("R7 idle precharge starts no wait", e_rp, 0);
        settle();
    endtask

    task automatic t_burst();
        c_act(0, 11'h0);
        c_rd(0);   chk("R8 read burst c1", burst_active, 1);
        nop(1);    chk("R8 nop keeps burst", burst_active, 1);
        nop(1);    chk("R8 read burst ends", burst_active, 0);
        c_rd(0);
        c_bst();   chk("R9 stop read burst", burst_active, 0);
        c_wr(0);
        c_bst();   chk("R9 stop ignored on write", burst_active, 1);
        nop(1);    chk("R8 write burst ends", burst_active, 0);
        settle();
    endtask

    task automatic t_refresh();
        c_ref();
        clr();
        nop(76);
        chk("R10 before limit", e_ref, 0);
        nop(1);
        chk("R10 at limit", e_ref, 1);
        nop(5);
        chk("R11 sticky", e_ref, 1);
        c_ref();
        err_clr = 1'b1; nop(1); err_clr = 1'b0;
        chk("R11 clear", e_ref, 0);
        c_ref();
        clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        cs_n = 1'b0;
        t_decode();
        t_banks();
        t_idle_access();
        t_mode();
        t_precharge_wait();
        t_burst();
        t_refresh();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule